// File: doc/BRIEF.md
# Line Clamp Pulse Generator

This block makes the per-line clamp enable for a video digitizer front end. It runs on the pixel clock and watches a raw horizontal sync input. That input first passes through a two-flop synchronizer. The block then picks out the trailing edge of the sync pulse, which is the end of the pulse as set by the programmed sync polarity. After that edge it waits a programmed number of pixel periods and then holds the clamp enable high for a second programmed number of pixel periods.

A mode input selects the source of the clamp. When it is set, the output instead follows an external clamp input whose active level is programmable. In that mode the internal delay and width settings have no effect on the output. The output is always an active-high clamp enable, registered once.

All settings arrive as static configuration ports. They should change only while the sync input rests at its inactive level and no pulse is running. There is no streaming data path: every pin is a plain control level, so there is no valid/ready handshake and no back-pressure.

Top module: `clamp_pulse_gen`

## Requirements
- R1: When a trailing sync edge is first sampled at rising clock edge e0, `clamp_en` first reads high just after edge e0+P+2, where P is `cfg_place` (internal mode).
- R2: The internal clamp pulse stays high for exactly W consecutive clock cycles, where W is `cfg_width`, and then returns low.
- R3: A programmed value of 0 for `cfg_place` or `cfg_width` behaves exactly like a value of 1.
- R4: When `cfg_sync_high` is 1, the sync pulse is high and its falling edge is the trailing edge. When it is 0, the pulse is low and its rising edge is the trailing edge. A leading edge never starts a clamp.
- R5: When `cfg_ext_sel` is 1, `clamp_en` after each rising clock edge equals 1 exactly when `ext_clamp` sampled at that edge equals `cfg_ext_high`. Sync edges, `cfg_place` and `cfg_width` have no effect on it.
- R6: A trailing edge that arrives while a delay or clamp interval is running restarts the whole sequence from the new edge.
- R7: After the clamp interval ends, `clamp_en` stays low until a new trailing edge arrives.
- R8: While `rst_n` is low, `clamp_en` is low and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_raw | input | 1 | Unsynchronized horizontal sync |
| ext_clamp | input | 1 | External clamp input |
| cfg_place | input | CNT_W | Pixel periods from the trailing edge to the start of the clamp |
| cfg_width | input | CNT_W | Clamp length in pixel periods |
| cfg_sync_high | input | 1 | 1: sync pulse is active high; 0: active low |
| cfg_ext_sel | input | 1 | 1: use the external clamp; 0: use the internal pulse |
| cfg_ext_high | input | 1 | 1: external clamp is active high; 0: active low |
| clamp_en | output | 1 | Active-high clamp enable |

## Verification
Full sync pulses with random delay, width, polarity and hold time are used to measure the start cycle and the length of the clamp. These runs separate a correct trailing-edge choice and a correct latency count from off-by-one errors and from triggering on the leading edge. Directed lines with zero settings, and a second pulse placed inside a running delay, separate the zero clamp and the restart behaviour from a hang or a stale count. Random external clamp levels, with the sync line toggling at the same time, show that the output follows only the polarity-corrected external input.

// File: rtl/clamp_pkg.sv
`timescale 1ns/1ps
package clamp_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_DELAY  = 2'd1,
    SEQ_ACTIVE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/clamp_sync_chain.sv
`timescale 1ns/1ps
module clamp_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clamp_trail_detect.sv
`timescale 1ns/1ps
module clamp_trail_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic sync_high,
  output logic trail
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= level;
  end

  // The end of an active-high pulse is a fall; the end of an active-low pulse is a rise.
  always_comb begin
    if (sync_high) trail = prev & ~level;
    else           trail = ~prev & level;
  end
endmodule

// File: rtl/clamp_sequencer.sv
`timescale 1ns/1ps
module clamp_sequencer
  import clamp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trail,
  input  logic [CNT_W-1:0] place,
  input  logic [CNT_W-1:0] width,
  output seq_state_e       state,
  output logic [CNT_W-1:0] cnt,
  output logic             active_next
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] place_eff;
  logic [CNT_W-1:0] width_eff;
  seq_state_e       nxt_state;
  logic [CNT_W-1:0] nxt_cnt;

  // A zero setting is treated as one so the sequence always ends.
  assign place_eff = (place == '0) ? ONE : place;
  assign width_eff = (width == '0) ? ONE : width;

  always_comb begin
    nxt_state = state;
    nxt_cnt   = cnt;
    if (trail) begin
      nxt_state = SEQ_DELAY;
      nxt_cnt   = place_eff;
    end else begin
      unique case (state)
        SEQ_DELAY: begin
          if (cnt <= ONE) begin
            nxt_state = SEQ_ACTIVE;
            nxt_cnt   = width_eff;
          end else begin
            nxt_cnt = cnt - ONE;
          end
        end
        SEQ_ACTIVE: begin
          if (cnt <= ONE) begin
            nxt_state = SEQ_IDLE;
            nxt_cnt   = '0;
          end else begin
            nxt_cnt = cnt - ONE;
          end
        end
        default: begin
          nxt_state = SEQ_IDLE;
          nxt_cnt   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt_state;
      cnt   <= nxt_cnt;
    end
  end

  assign active_next = (nxt_state == SEQ_ACTIVE);
endmodule

// File: rtl/clamp_out_select.sv
`timescale 1ns/1ps
module clamp_out_select (
  input  logic clk,
  input  logic rst_n,
  input  logic int_active,
  input  logic ext_clamp,
  input  logic ext_sel,
  input  logic ext_high,
  output logic clamp
);
  logic ext_active;

  assign ext_active = ~(ext_clamp ^ ext_high);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       clamp <= 1'b0;
    else if (ext_sel) clamp <= ext_active;
    else              clamp <= int_active;
  end
endmodule

// File: rtl/clamp_pulse_gen.sv
`timescale 1ns/1ps
module clamp_pulse_gen
  import clamp_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_raw,
  input  logic             ext_clamp,
  input  logic [CNT_W-1:0] cfg_place,
  input  logic [CNT_W-1:0] cfg_width,
  input  logic             cfg_sync_high,
  input  logic             cfg_ext_sel,
  input  logic             cfg_ext_high,
  output logic             clamp_en
);
  logic             hs_sync;
  logic             trail_pulse;
  seq_state_e       seq_state;
  logic [CNT_W-1:0] seq_cnt;
  logic             seq_active_next;

  clamp_sync_chain #(.STAGES(SYNC_STAGES)) u_hs_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (hsync_raw),
    .q (hs_sync)
  );

  clamp_trail_detect u_trail (
    .clk (clk),
    .rst_n (rst_n),
    .level (hs_sync),
    .sync_high (cfg_sync_high),
    .trail (trail_pulse)
  );

  clamp_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk (clk),
    .rst_n (rst_n),
    .trail (trail_pulse),
    .place (cfg_place),
    .width (cfg_width),
    .state (seq_state),
    .cnt (seq_cnt),
    .active_next (seq_active_next)
  );

  clamp_out_select u_out (
    .clk (clk),
    .rst_n (rst_n),
    .int_active (seq_active_next),
    .ext_clamp (ext_clamp),
    .ext_sel (cfg_ext_sel),
    .ext_high (cfg_ext_high),
    .clamp (clamp_en)
  );
endmodule

// File: rtl/clamp_pulse_gen_chk.sv
`timescale 1ns/1ps
module clamp_pulse_gen_chk
  import clamp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_clamp,
  input logic [CNT_W-1:0] cfg_place,
  input logic             cfg_ext_sel,
  input logic             cfg_ext_high,
  input logic             clamp_en,
  input logic [1:0]       state,
  input logic [CNT_W-1:0] cnt,
  input logic             trail
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_ext_sel) |-> (clamp_en == ($past(ext_clamp) == $past(cfg_ext_high)))); // R5

  AST_INT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_ext_sel) |-> (clamp_en == (state == 2'(SEQ_ACTIVE)))); // R1

  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    trail |=> (state == 2'(SEQ_DELAY)) &&
              (cnt == (($past(cfg_place) == '0) ? ONE : $past(cfg_place)))); // R6

  AST_DELAY_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'(SEQ_DELAY) && cnt == ONE && !trail) |=> (state == 2'(SEQ_ACTIVE))); // R1

  AST_ACTIVE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'(SEQ_ACTIVE) && cnt == ONE && !trail) |=> (state == 2'(SEQ_IDLE))); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'(SEQ_IDLE) && !trail) |=> (state == 2'(SEQ_IDLE))); // R7

  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 2'(SEQ_IDLE)) |-> (cnt != '0)); // R3
endmodule

bind clamp_pulse_gen clamp_pulse_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .ext_clamp (ext_clamp),
  .cfg_place (cfg_place),
  .cfg_ext_sel (cfg_ext_sel),
  .cfg_ext_high (cfg_ext_high),
  .clamp_en (clamp_en),
  .state (seq_state),
  .cnt (seq_cnt),
  .trail (trail_pulse)
);

// File: tb/clamp_pulse_gen_bench.sv
`timescale 1ns/1ps
module clamp_pulse_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync_raw = 1'b0;
  logic       ext_clamp = 1'b0;
  logic [7:0] cfg_place = 8'h80;
  logic [7:0] cfg_width = 8'h80;
  logic       cfg_sync_high = 1'b1;
  logic       cfg_ext_sel = 1'b0;
  logic       cfg_ext_high = 1'b1;
  logic       clamp_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clamp_pulse_gen u_clamp_pulse_gen (
    .clk (clk),
    .rst_n (rst_n),
    .hsync_raw (hsync_raw),
    .ext_clamp (ext_clamp),
    .cfg_place (cfg_place),
    .cfg_width (cfg_width),
    .cfg_sync_high (cfg_sync_high),
    .cfg_ext_sel (cfg_ext_sel),
    .cfg_ext_high (cfg_ext_high),
    .clamp_en (clamp_en)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  // Expected first-high negedge index after the trailing-edge drive: two sync flops, the edge register, then P delay cycles.
  function automatic int exp_start(int p);
    return eff(p) + 3;
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive the trailing transition at this negedge, then measure when the pulse starts and how long it lasts.
  task automatic measure(int p, int w, string req);
    int start = -1;
    int len = 0;
    int early = 0;
    int late = 0;
    hsync_raw = ~cfg_sync_high;
    for (int i = 1; i <= 600; i++) begin
      @(negedge clk);
      if (clamp_en) begin
        if (start < 0) start = i;
        if (late == 0) len++;
        else early++;
      end else if (start >= 0) begin
        late++;
      end
      if (late >= 20) break;
    end
    chk({req, " start"}, start, exp_start(p));
    chk({req, " width"}, len, eff(w));
    chk({req, " R7 quiet after end"}, early, 0);
  endtask

  // One whole line: leading edge, hold, then trailing edge.
  task automatic run_line(int p, int w, int hold, string req);
    int seen = 0;
    cfg_place = 8'(p);
    cfg_width = 8'(w);
    hsync_raw = cfg_sync_high;
    for (int i = 0; i < hold + 4; i++) begin
      @(negedge clk);
      if (clamp_en) seen++;
    end
    chk("R4 leading edge starts nothing", seen, 0);
    measure(p, w, req);
  endtask

  task automatic set_pol(bit hi);
    cfg_sync_high = hi;
    hsync_raw = ~hi;
    idle(300);
  endtask

  initial begin
    idle(150000);
    chk("watchdog expired", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    idle(3);
    chk("R8 clamp low in reset", int'(clamp_en), 0);
    rst_n = 1'b1;
    idle(3);
    chk("R8 clamp low after reset", int'(clamp_en), 0);

    // Directed lines with both polarities.
    cfg_place = 8'd8; cfg_width = 8'd16;
    run_line(8, 16, 5, "R1 R2 R4 active-high");
    set_pol(1'b0);
    run_line(5, 3, 6, "R1 R2 R4 active-low");
    set_pol(1'b1);

    // Zero settings behave as one.
    run_line(0, 0, 3, "R3 zero place and width");
    run_line(1, 1, 2, "R3 one place and width");

    // Restart: a second trailing edge inside the delay.
    begin
      int seen = 0;
      cfg_place = 8'd12; cfg_width = 8'd4;
      hsync_raw = 1'b1; idle(3);
      hsync_raw = 1'b0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (clamp_en) seen++;
      end
      hsync_raw = 1'b1;
      @(negedge clk);
      if (clamp_en) seen++;
      chk("R6 nothing during first delay", seen, 0);
      measure(12, 4, "R6 restart in delay");
    end

    // Restart: a second trailing edge during the clamp itself.
    begin
      cfg_place = 8'd2; cfg_width = 8'd30;
      hsync_raw = 1'b1; idle(3);
      hsync_raw = 1'b0;
      idle(8);
      chk("R6 clamp running", int'(clamp_en), 1);
      hsync_raw = 1'b1;
      @(negedge clk);
      hsync_raw = 1'b0;
      idle(4);
      chk("R6 clamp dropped at restart", int'(clamp_en), 0);
      idle(60);
    end

    // Random lines.
    for (int n = 0; n < 24; n++) begin
      int p = int'($urandom_range(0, 30));
      int w = int'($urandom_range(0, 30));
      int h = int'($urandom_range(1, 8));
      bit pol = 1'($urandom_range(0, 1));
      if (pol != cfg_sync_high) set_pol(pol);
      run_line(p, w, h, "R1 R2 R4 random line");
    end
    set_pol(1'b1);

    // External clamp mode.
    cfg_ext_sel = 1'b1;
    cfg_place = 8'd1; cfg_width = 8'd1;
    for (int n = 0; n < 60; n++) begin
      bit e = 1'($urandom_range(0, 1));
      bit hp = 1'($urandom_range(0, 1));
      ext_clamp = e;
      cfg_ext_high = hp;
      hsync_raw = 1'($urandom_range(0, 1));
      @(negedge clk);
      chk("R5 follows external clamp", int'(clamp_en), int'(e == hp));
    end
    ext_clamp = 1'b0; cfg_ext_high = 1'b1;
    hsync_raw = 1'b1; idle(3); hsync_raw = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (clamp_en) seen++;
      end
      chk("R5 sync edge has no effect in external mode", seen, 0);
    end
    cfg_ext_sel = 1'b0;
    idle(5);
    chk("R7 idle after leaving external mode", int'(clamp_en), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule